// File: doc/BRIEF.md
# Dirty-Page Display Update Scanner

This block keeps the dirty state of a framebuffer and turns it into display update rectangles. The indexed plane has one dirty bit per page. A page holds four scanlines, so one bit stands for one group of four rows. When the display runs in 24-bit mode, two more planes are tracked: the direct-colour plane and the control plane. Each of them has four pages for every row group. Writers mark pages dirty through three mark ports. A full-invalidate input marks every page in every plane dirty.

A start pulse begins a scan. The scan walks the row groups from the top and stops at the configured display height. Adjacent dirty groups are merged into one vertical run. Each run is emitted as a record holding the first row, the height in rows and the full display width; the horizontal origin is always column zero. Records leave on a valid/ready handshake, and the scan waits while the consumer is not ready. At the end the scanner clears the dirty bits it consumed and pulses a done output. Pixel copying belongs to the consumer.

Top module: `dps_scanner`

## Requirements
- R1: One indexed-plane bit covers four rows: group g is rows 4g to 4g+3. Every record therefore has `rect_y` and `rect_h` as multiples of four, with `rect_h` nonzero.
- R2: A scan examines groups 0, 1, 2 … in order and stops at the first group whose first row is at or past the display height captured at start, or after the last group. Groups that are not examined keep their dirty bits.
- R3: A run of consecutive dirty groups gives exactly one record. When the run reaches a clean group, the record carries `rect_y` = first row of the run and `rect_h` = first row of the clean group minus `rect_y`. Records come out in top-down order.
- R4: If a run is still open when the scan stops, it is emitted with `rect_h` measured up to 4 × (number of groups examined). This can reach past a display height that is not a multiple of four.
- R5: Every record has `rect_w` equal to `disp_width` as captured at the start pulse.
- R6: With `depth24`=1 at start, group g counts as dirty if indexed page g is dirty, or any direct-plane page 4g..4g+3 is dirty, or any control-plane page 4g..4g+3 is dirty. With `depth24`=0, the direct and control planes are not consulted and their bits stay set.
- R7: After the scan, the scanner clears the bits it observed set, inside the span from the lowest to the highest dirty group seen. An immediate rescan with no new marks yields no records.
- R8: A page marked by a writer during a scan, after its group has been examined, is still dirty after the end-of-scan clear.
- R9: A one-cycle `invalidate` marks all pages of all three planes dirty.
- R10: Reset (`rst_n`=0, synchronous) clears every dirty bit, drops `rect_valid` and `scan_done`, and returns to idle.
- R11: While `rect_valid`=1 and `rect_ready`=0, `rect_valid`, `rect_y`, `rect_h` and `rect_w` hold steady. No record is lost or repeated under backpressure.
- R12: `scan_done` is a one-cycle pulse. It comes after the last record has been accepted and the clear has been applied, and it is never high together with `rect_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan; ignored while a scan is running |
| depth24 | input | 1 | Select 24-bit mode (three planes), captured at start |
| disp_height | input | YW | Display height in rows, captured at start |
| disp_width | input | XW | Display width in pixels, captured at start |
| invalidate | input | 1 | Mark every page of all planes dirty |
| idx_mark_vld | input | 1 | Mark one indexed-plane page dirty |
| idx_mark_page | input | GIW | Indexed page (row group) to mark |
| dir_mark_vld | input | 1 | Mark one direct-plane page dirty |
| dir_mark_page | input | PW | Direct-plane page to mark |
| ctl_mark_vld | input | 1 | Mark one control-plane page dirty |
| ctl_mark_page | input | PW | Control-plane page to mark |
| rect_valid | output | 1 | Update record valid |
| rect_ready | input | 1 | Consumer accepts the record |
| rect_y | output | YW | First row of the record |
| rect_h | output | YW | Height of the record in rows |
| rect_w | output | XW | Width of the record (full display width) |
| scan_done | output | 1 | One-cycle pulse at the end of a scan |

## Verification
The bench builds the scanner with eight row groups, so there are 8 indexed pages and 32 pages in each of the other planes, and uses an 11-bit width field. At this size a 32-row display reaches every group. Patterns like a run that touches the last group or a height that ends in the middle of a group take only a few marks. A full-invalidate case spans the whole bitmap in a few dozen cycles. The small page count also makes the end-of-scan clear easy to observe: a second scan returns exactly the bits that survived. The same holds for the pages the bench re-marks while a record is stalled.

// File: rtl/dps_pkg.sv
// Shared types and constants of the dirty-page scanner.
// Assumes: rows per group and pages per group in the wide planes are both four.
package dps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_EMIT,
        ST_LAST,
        ST_CLEAR
    } scan_state_e;

    localparam int unsigned ROW_SHIFT = 2;      // rows per group = 1 << ROW_SHIFT
    localparam int unsigned SUB_PAGES = 4;      // wide-plane pages per row group
endpackage

// File: rtl/dps_plane.sv
// One dirty-bit plane.
// Each bit is set by a writer mark or by a full invalidate, and cleared by
// the scanner's clear mask. A set in the same cycle beats a clear.
// Assumes: mask inputs are already decoded to one bit per page.
module dps_plane #(
    parameter int unsigned NBITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set_mask,
    input  logic             inv_all,
    input  logic [NBITS-1:0] clr_mask,
    output logic [NBITS-1:0] bits
);
    // Hold the dirty bits: reset empties, sets win over clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            bits <= (bits & ~clr_mask) | set_mask | {NBITS{inv_all}};
        end
    end
endmodule

// File: rtl/dps_group_eval.sv
// Combines the dirty state of one row group.
// It also reports which bits were seen set, so only those can be cleared later.
// Assumes: grp_ok is low whenever gi is outside the plane.
module dps_group_eval #(
    parameter int unsigned NGROUPS = 8
) (
    input  logic [$clog2(NGROUPS)-1:0] gi,
    input  logic                       grp_ok,
    input  logic                       mode24,
    input  logic [NGROUPS-1:0]         idx_bits,
    input  logic [4*NGROUPS-1:0]       dir_bits,
    input  logic [4*NGROUPS-1:0]       ctl_bits,
    output logic                       grp_dirty,
    output logic [NGROUPS-1:0]         obs_idx,
    output logic [4*NGROUPS-1:0]       obs_dir,
    output logic [4*NGROUPS-1:0]       obs_ctl
);
    import dps_pkg::*;

    localparam int unsigned GIW = $clog2(NGROUPS);
    localparam int unsigned NP  = SUB_PAGES * NGROUPS;

    logic                 idx_hit;
    logic [SUB_PAGES-1:0] dir_nib;
    logic [SUB_PAGES-1:0] ctl_nib;
    logic [GIW+1:0]       sub_base;

    assign sub_base = {gi, 2'b00};

    // Pick this group's bits; the wide planes count only in 24-bit mode.
    always_comb begin
        idx_hit = 1'b0;
        dir_nib = '0;
        ctl_nib = '0;
        if (grp_ok) begin
            idx_hit = idx_bits[gi];
            if (mode24) begin
                dir_nib = dir_bits[sub_base +: SUB_PAGES];
                ctl_nib = ctl_bits[sub_base +: SUB_PAGES];
            end
        end
    end

    // Verdict for the group and the bits it observed.
    always_comb begin
        grp_dirty = idx_hit | (|dir_nib) | (|ctl_nib);
        obs_idx   = idx_hit ? (NGROUPS'(1) << gi) : '0;
        obs_dir   = NP'(dir_nib) << sub_base;
        obs_ctl   = NP'(ctl_nib) << sub_base;
    end
endmodule

// File: rtl/dps_scan_ctrl.sv
// Scan sequencer.
// It walks the row groups, merges dirty runs into records, stalls on
// backpressure, tracks the dirty span and the observed bits, and issues the
// end-of-scan clear.
// Assumes: disp_height <= 4 * NGROUPS; NGROUPS >= 2.
module dps_scan_ctrl #(
    parameter int unsigned NGROUPS = 8,
    parameter int unsigned XW      = 11
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic                              depth24,
    input  logic [$clog2(4*NGROUPS+1)-1:0]    disp_height,
    input  logic [XW-1:0]                     disp_width,
    input  logic                              grp_dirty,
    input  logic [NGROUPS-1:0]                obs_idx,
    input  logic [4*NGROUPS-1:0]              obs_dir,
    input  logic [4*NGROUPS-1:0]              obs_ctl,
    input  logic [NGROUPS-1:0]                set_idx,
    input  logic [4*NGROUPS-1:0]              set_dir,
    input  logic [4*NGROUPS-1:0]              set_ctl,
    input  logic                              inv_all,
    output logic [$clog2(NGROUPS)-1:0]        gi,
    output logic                              grp_ok,
    output logic                              mode24,
    output logic [NGROUPS-1:0]                clr_idx,
    output logic [4*NGROUPS-1:0]              clr_dir,
    output logic [4*NGROUPS-1:0]              clr_ctl,
    output logic                              rect_valid,
    input  logic                              rect_ready,
    output logic [$clog2(4*NGROUPS+1)-1:0]    rect_y,
    output logic [$clog2(4*NGROUPS+1)-1:0]    rect_h,
    output logic [XW-1:0]                     rect_w,
    output logic                              scan_done
);
    import dps_pkg::*;

    localparam int unsigned YW  = $clog2(4*NGROUPS+1);
    localparam int unsigned GW  = $clog2(NGROUPS+1);
    localparam int unsigned GIW = $clog2(NGROUPS);
    localparam int unsigned NP  = SUB_PAGES * NGROUPS;

    scan_state_e      state;
    logic [GW-1:0]    grp;
    logic [YW-1:0]    row;
    logic [YW-1:0]    hgt_q;
    logic [XW-1:0]    wid_q;
    logic             run_open;
    logic [YW-1:0]    run_start;
    logic [GIW-1:0]   pg_min;
    logic [GIW-1:0]   pg_max;
    logic             scan_end;
    logic [NGROUPS-1:0] seen_idx;
    logic [NP-1:0]    seen_dir;
    logic [NP-1:0]    seen_ctl;
    logic [NGROUPS-1:0] rng_idx;
    logic [NP-1:0]    rng_sub;

    assign row      = YW'(grp) << ROW_SHIFT;
    assign scan_end = (grp >= GW'(NGROUPS)) || (row >= hgt_q);
    assign gi       = grp[GIW-1:0];
    assign grp_ok   = (state == ST_SCAN) && !scan_end;

    // Main sequencer: group walk, run merging, record handshake, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            grp        <= '0;
            hgt_q      <= '0;
            wid_q      <= '0;
            mode24     <= 1'b0;
            run_open   <= 1'b0;
            run_start  <= '0;
            pg_min     <= '0;
            pg_max     <= '0;
            rect_valid <= 1'b0;
            rect_y     <= '0;
            rect_h     <= '0;
            rect_w     <= '0;
            scan_done  <= 1'b0;
        end else begin
            scan_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state    <= ST_SCAN;
                        grp      <= '0;
                        hgt_q    <= disp_height;
                        wid_q    <= disp_width;
                        mode24   <= depth24;
                        run_open <= 1'b0;
                        pg_min   <= GIW'(NGROUPS - 1);
                        pg_max   <= '0;
                    end
                end
                ST_SCAN: begin
                    if (scan_end) begin
                        if (run_open) begin
                            rect_valid <= 1'b1;
                            rect_y     <= run_start;
                            rect_h     <= row - run_start;
                            rect_w     <= wid_q;
                            run_open   <= 1'b0;
                            state      <= ST_LAST;
                        end else begin
                            state <= ST_CLEAR;
                        end
                    end else if (grp_dirty) begin
                        if (!run_open) begin
                            run_open  <= 1'b1;
                            run_start <= row;
                        end
                        if (gi < pg_min) pg_min <= gi;
                        if (gi > pg_max) pg_max <= gi;
                        grp <= grp + 1'b1;
                    end else begin
                        if (run_open) begin
                            rect_valid <= 1'b1;
                            rect_y     <= run_start;
                            rect_h     <= row - run_start;
                            rect_w     <= wid_q;
                            run_open   <= 1'b0;
                            state      <= ST_EMIT;
                        end
                        grp <= grp + 1'b1;
                    end
                end
                ST_EMIT: begin
                    if (rect_ready) begin
                        rect_valid <= 1'b0;
                        state      <= ST_SCAN;
                    end
                end
                ST_LAST: begin
                    if (rect_ready) begin
                        rect_valid <= 1'b0;
                        state      <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    scan_done <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Observed-bit record: gain what the scan sees, lose what writers re-mark.
    always_ff @(posedge clk) begin
        if (!rst_n || (state == ST_IDLE && start)) begin
            seen_idx <= '0;
            seen_dir <= '0;
            seen_ctl <= '0;
        end else begin
            seen_idx <= (seen_idx | obs_idx) & ~set_idx & ~{NGROUPS{inv_all}};
            seen_dir <= (seen_dir | obs_dir) & ~set_dir & ~{NP{inv_all}};
            seen_ctl <= (seen_ctl | obs_ctl) & ~set_ctl & ~{NP{inv_all}};
        end
    end

    // Span of dirty groups, per indexed page and per wide-plane page.
    for (genvar i = 0; i < NGROUPS; i++) begin : g_rng_idx
        assign rng_idx[i] = (GIW'(i) >= pg_min) && (GIW'(i) <= pg_max);
    end
    for (genvar j = 0; j < NP; j++) begin : g_rng_sub
        localparam int unsigned OWNER = j / SUB_PAGES;
        assign rng_sub[j] = (GIW'(OWNER) >= pg_min) && (GIW'(OWNER) <= pg_max);
    end

    // Clear only in the clear state: observed bits inside the dirty span.
    always_comb begin
        clr_idx = '0;
        clr_dir = '0;
        clr_ctl = '0;
        if (state == ST_CLEAR) begin
            clr_idx = seen_idx & rng_idx;
            clr_dir = seen_dir & rng_sub;
            clr_ctl = seen_ctl & rng_sub;
        end
    end
endmodule

// File: rtl/dps_scanner.sv
// Top of the dirty-page scanner.
// It decodes writer marks, holds the three dirty planes, evaluates one row
// group per cycle and emits (row, height, width) update records.
// Assumes: the consumer draws each record from column zero across the width.
module dps_scanner #(
    parameter int unsigned NGROUPS = 192,
    parameter int unsigned XW      = 11,
    localparam int unsigned YW     = $clog2(4*NGROUPS+1),
    localparam int unsigned GIW    = $clog2(NGROUPS),
    localparam int unsigned PW     = $clog2(4*NGROUPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           depth24,
    input  logic [YW-1:0]  disp_height,
    input  logic [XW-1:0]  disp_width,
    input  logic           invalidate,
    input  logic           idx_mark_vld,
    input  logic [GIW-1:0] idx_mark_page,
    input  logic           dir_mark_vld,
    input  logic [PW-1:0]  dir_mark_page,
    input  logic           ctl_mark_vld,
    input  logic [PW-1:0]  ctl_mark_page,
    output logic           rect_valid,
    input  logic           rect_ready,
    output logic [YW-1:0]  rect_y,
    output logic [YW-1:0]  rect_h,
    output logic [XW-1:0]  rect_w,
    output logic           scan_done
);
    localparam int unsigned NP = 4 * NGROUPS;

    logic [NGROUPS-1:0] set_idx, clr_idx, idx_bits, obs_idx;
    logic [NP-1:0]      set_dir, clr_dir, dir_bits, obs_dir;
    logic [NP-1:0]      set_ctl, clr_ctl, ctl_bits, obs_ctl;
    logic [GIW-1:0]     gi;
    logic               grp_ok;
    logic               mode24;
    logic               grp_dirty;

    // Decode writer marks into one-hot set masks.
    always_comb begin
        set_idx = idx_mark_vld ? (NGROUPS'(1) << idx_mark_page) : '0;
        set_dir = dir_mark_vld ? (NP'(1) << dir_mark_page) : '0;
        set_ctl = ctl_mark_vld ? (NP'(1) << ctl_mark_page) : '0;
    end

    dps_plane #(.NBITS(NGROUPS)) u_idx_plane (
        .clk(clk), .rst_n(rst_n), .set_mask(set_idx), .inv_all(invalidate),
        .clr_mask(clr_idx), .bits(idx_bits)
    );
    dps_plane #(.NBITS(NP)) u_dir_plane (
        .clk(clk), .rst_n(rst_n), .set_mask(set_dir), .inv_all(invalidate),
        .clr_mask(clr_dir), .bits(dir_bits)
    );
    dps_plane #(.NBITS(NP)) u_ctl_plane (
        .clk(clk), .rst_n(rst_n), .set_mask(set_ctl), .inv_all(invalidate),
        .clr_mask(clr_ctl), .bits(ctl_bits)
    );

    dps_group_eval #(.NGROUPS(NGROUPS)) u_eval (
        .gi(gi), .grp_ok(grp_ok), .mode24(mode24),
        .idx_bits(idx_bits), .dir_bits(dir_bits), .ctl_bits(ctl_bits),
        .grp_dirty(grp_dirty), .obs_idx(obs_idx), .obs_dir(obs_dir), .obs_ctl(obs_ctl)
    );

    dps_scan_ctrl #(.NGROUPS(NGROUPS), .XW(XW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .depth24(depth24),
        .disp_height(disp_height), .disp_width(disp_width),
        .grp_dirty(grp_dirty), .obs_idx(obs_idx), .obs_dir(obs_dir), .obs_ctl(obs_ctl),
        .set_idx(set_idx), .set_dir(set_dir), .set_ctl(set_ctl), .inv_all(invalidate),
        .gi(gi), .grp_ok(grp_ok), .mode24(mode24),
        .clr_idx(clr_idx), .clr_dir(clr_dir), .clr_ctl(clr_ctl),
        .rect_valid(rect_valid), .rect_ready(rect_ready),
        .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w), .scan_done(scan_done)
    );
endmodule

// File: rtl/dps_scanner_chk.sv
// Port-level protocol checker for the dirty-page scanner, bound to the top.
module dps_scanner_chk #(
    parameter int unsigned YW = 6,
    parameter int unsigned XW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rect_valid,
    input logic          rect_ready,
    input logic [YW-1:0] rect_y,
    input logic [YW-1:0] rect_h,
    input logic [XW-1:0] rect_w,
    input logic          scan_done
);
    // R11: a stalled record keeps its fields
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid && !rect_ready |=> rect_valid && $stable(rect_y) && $stable(rect_h) && $stable(rect_w));

    // R1: records are group aligned and never empty
    p_rect_shape_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> (rect_y[1:0] == 2'b00) && (rect_h[1:0] == 2'b00) && (rect_h != '0));

    // R12: done lasts one cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    // R12: done never overlaps a pending record
    p_done_no_rect_r12: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !rect_valid);

    // R10: reset leaves the outputs idle
    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> !rect_valid && !scan_done);
endmodule

bind dps_scanner dps_scanner_chk #(.YW(YW), .XW(XW)) u_chk (
    .clk(clk), .rst_n(rst_n), .rect_valid(rect_valid), .rect_ready(rect_ready),
    .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w), .scan_done(scan_done)
);

// File: tb/dps_scanner_tb_top.sv
// Directed bench for the dirty-page scanner with a reference model of the planes.
module dps_scanner_tb_top;
    localparam int NG  = 8;
    localparam int XW  = 11;
    localparam int YW  = $clog2(4*NG+1);
    localparam int GIW = $clog2(NG);
    localparam int PW  = $clog2(4*NG);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, depth24 = 1'b0, invalidate = 1'b0;
    logic [YW-1:0] disp_height = '0;
    logic [XW-1:0] disp_width = '0;
    logic idx_mark_vld = 1'b0, dir_mark_vld = 1'b0, ctl_mark_vld = 1'b0;
    logic [GIW-1:0] idx_mark_page = '0;
    logic [PW-1:0] dir_mark_page = '0, ctl_mark_page = '0;
    logic rect_valid, rect_ready = 1'b1, scan_done;
    logic [YW-1:0] rect_y, rect_h;
    logic [XW-1:0] rect_w;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    logic [NG-1:0]   m_idx = '0;
    logic [4*NG-1:0] m_dir = '0, m_ctl = '0;

    always #2 clk = ~clk;

    dps_scanner #(.NGROUPS(NG), .XW(XW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .depth24(depth24),
        .disp_height(disp_height), .disp_width(disp_width), .invalidate(invalidate),
        .idx_mark_vld(idx_mark_vld), .idx_mark_page(idx_mark_page),
        .dir_mark_vld(dir_mark_vld), .dir_mark_page(dir_mark_page),
        .ctl_mark_vld(ctl_mark_vld), .ctl_mark_page(ctl_mark_page),
        .rect_valid(rect_valid), .rect_ready(rect_ready),
        .rect_y(rect_y), .rect_h(rect_h), .rect_w(rect_w), .scan_done(scan_done)
    );

    task automatic summary_and_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run did not finish, cycles %0d expected below 150000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic mark(input int plane, input int page);
        @(negedge clk);
        case (plane)
            0: begin idx_mark_vld = 1'b1; idx_mark_page = GIW'(page); m_idx[page] = 1'b1; end
            1: begin dir_mark_vld = 1'b1; dir_mark_page = PW'(page);  m_dir[page] = 1'b1; end
            default: begin ctl_mark_vld = 1'b1; ctl_mark_page = PW'(page); m_ctl[page] = 1'b1; end
        endcase
        @(negedge clk);
        idx_mark_vld = 1'b0; dir_mark_vld = 1'b0; ctl_mark_vld = 1'b0;
    endtask

    task automatic do_invalidate();
        @(negedge clk);
        invalidate = 1'b1;
        m_idx = '1; m_dir = '1; m_ctl = '1;
        @(negedge clk);
        invalidate = 1'b0;
    endtask

    // Run one scan and compare records against the model.
    // rmode 0: always ready, 1: ready one cycle in three.
    // poke >= 0: re-mark that indexed page while the first record is stalled.
    task automatic run_scan(input string req, input bit m24, input int hgt, input int wid,
                            input int rmode, input int poke);
        int ey[16]; int eh[16]; int ne = 0;
        int gy[16]; int gh[16]; int gw[16]; int ng = 0;
        bit open = 1'b0; int rs = 0; int nscan = 0; bit poked = 1'b0; bit fin = 1'b0;
        for (int g = 0; g < NG && 4*g < hgt; g++) begin
            bit d;
            d = m_idx[g] | (m24 & ((|m_dir[4*g +: 4]) | (|m_ctl[4*g +: 4])));
            nscan = nscan + 1;
            if (d) begin
                if (!open) begin open = 1'b1; rs = 4*g; end
                m_idx[g] = 1'b0;
                if (m24) begin m_dir[4*g +: 4] = 4'h0; m_ctl[4*g +: 4] = 4'h0; end
            end else if (open) begin
                ey[ne] = rs; eh[ne] = 4*g - rs; ne = ne + 1; open = 1'b0;
            end
        end
        if (open) begin ey[ne] = rs; eh[ne] = 4*nscan - rs; ne = ne + 1; end
        if (poke >= 0) m_idx[poke] = 1'b1;

        @(negedge clk);
        depth24 = m24; disp_height = YW'(hgt); disp_width = XW'(wid); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 2000 && !fin; k++) begin
            rect_ready = (rmode == 0) ? 1'b1 : (k % 3 == 2);
            if (poke >= 0 && rect_valid && !poked) begin
                rect_ready = 1'b0;
                idx_mark_vld = 1'b1; idx_mark_page = GIW'(poke); poked = 1'b1;
            end else begin
                idx_mark_vld = 1'b0;
            end
            if (rect_valid && rect_ready && ng < 16) begin
                gy[ng] = int'(rect_y); gh[ng] = int'(rect_h); gw[ng] = int'(rect_w); ng = ng + 1;
            end
            if (scan_done) fin = 1'b1;
            @(negedge clk);
        end
        idx_mark_vld = 1'b0; rect_ready = 1'b1;
        chk(fin, "R12", "scan_done seen", int'(fin), 1);
        chk(ng == ne, req, "record count", ng, ne);
        for (int i = 0; i < ne && i < ng; i++) begin
            chk(gy[i] == ey[i], req, $sformatf("rect_y of record %0d", i), gy[i], ey[i]);
            chk(gh[i] == eh[i], req, $sformatf("rect_h of record %0d", i), gh[i], eh[i]);
            chk(gw[i] == wid, "R5", $sformatf("rect_w of record %0d", i), gw[i], wid);
        end
    endtask

    // R10: reset state and empty planes
    task automatic t_reset();
        chk(rect_valid == 1'b0, "R10", "rect_valid after reset", int'(rect_valid), 0);
        chk(scan_done == 1'b0, "R10", "scan_done after reset", int'(scan_done), 0);
        run_scan("R10", 1'b1, 32, 640, 0, -1);
    endtask

    // R1 R3 R7: one run in the middle, then a rescan finds nothing
    task automatic t_single_run();
        mark(0, 2); mark(0, 3);
        run_scan("R3", 1'b0, 32, 800, 0, -1);
        run_scan("R7", 1'b0, 32, 800, 0, -1);
    endtask

    // R3: two separate runs, top-down order
    task automatic t_two_runs();
        mark(0, 0); mark(0, 2); mark(0, 3); mark(0, 4);
        run_scan("R3", 1'b0, 32, 1024, 0, -1);
    endtask

    // R4: run reaching the last group
    task automatic t_tail_run();
        mark(0, 6); mark(0, 7);
        run_scan("R4", 1'b0, 32, 1024, 0, -1);
    endtask

    // R2 R4: height mid-group; a group past the height stays dirty
    task automatic t_partial_height();
        mark(0, 5); mark(0, 6);
        run_scan("R4", 1'b0, 22, 512, 0, -1);
        run_scan("R2", 1'b0, 32, 512, 0, -1);
    endtask

    // R6: wide planes count only in 24-bit mode and survive 8-bit scans
    task automatic t_mode24();
        mark(1, 9); mark(2, 17); mark(1, 5);
        run_scan("R6", 1'b0, 32, 1024, 0, -1);
        run_scan("R6", 1'b1, 32, 1024, 0, -1);
        run_scan("R7", 1'b1, 32, 1024, 0, -1);
    endtask

    // R9: invalidate marks every plane
    task automatic t_invalidate();
        do_invalidate();
        run_scan("R9", 1'b0, 32, 1024, 0, -1);
        run_scan("R9", 1'b1, 32, 1024, 0, -1);
    endtask

    // R11: backpressure loses no record
    task automatic t_backpressure();
        mark(0, 0); mark(0, 2); mark(0, 5); mark(0, 7);
        run_scan("R11", 1'b0, 32, 300, 1, -1);
    endtask

    // R8: page re-marked during the scan survives the clear
    task automatic t_remark();
        mark(0, 0); mark(0, 3);
        run_scan("R8", 1'b0, 32, 256, 0, 0);
        run_scan("R8", 1'b0, 32, 256, 0, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_run();
        t_two_runs();
        t_tail_run();
        t_partial_height();
        t_mode24();
        t_invalidate();
        t_backpressure();
        t_remark();
        repeat (4) @(negedge clk);
        summary_and_end();
    end
endmodule